// File: doc/BRIEF.md
# Tiling fence register sequencer

This block keeps a bank of tiling fence entries. Each entry maps one page-aligned linear address range onto a detiler. The entry records the tiling layout (X or Y) and the row pitch. A host asks for an update by giving an entry index, a tiling mode, a first page, a page count and a stride in bytes. The block encodes these fields into a 64-bit entry. It then commits the entry to the bank over an internal 32-bit register bus in a fixed order, so that a partly written entry is never live.

The block keeps a shadow copy of every encoded entry. A restore pulse replays all shadow entries into the bank in index order, each with the same safe order. This is used after the bank has lost its contents, for example on resume.

A combinational lookup port takes a byte address and reports the first valid entry whose page range covers it.

Top module: `fence_seq_top`

## Requirements
- R1: The high word of a tiled entry is `(first_page + page_count - 1) << 12`, which is the byte address of the last page of the range. Bits [11:0] of the high word are zero.
- R2: The low word of a tiled entry has this layout: bits [31:12] hold the first page; bits [11:2] hold the pitch code, `stride/128 - 1`; bit 1 is set for Y tiling and clear for X tiling; bit 0 is the valid flag, set to 1.
- R3: Mode code 3 is refused. A tiled request is also refused when its stride is zero or not a multiple of 128, when its page count is zero, or when its last page lies beyond page 0xFFFFF. A refused request raises `rej` for one cycle in the cycle after it is sampled. It causes no bus activity and leaves the shadow copy and the bank unchanged.
- R4: Mode code 0 (untiled or release) commits all zeros to both words, so the entry stops matching lookups.
- R5: An accepted update takes exactly five cycles on the bus, in this order: write 0 to the low word, read the low word, write the high word, write the encoded low word, read the low word. The low word of entry i is at bus word address 2i and the high word at 2i+1. The high word is written only while the entry's valid bit is clear.
- R6: The first readback returns 0 and the final readback returns the encoded low word.
- R7: `busy` is high from the first write cycle through the final readback cycle and low otherwise. A request or restore that arrives while `busy` is high is ignored.
- R8: A restore pulse sampled while idle replays all 32 entries from the shadow copy in ascending index order. This takes 160 busy cycles. A restore wins over a request sampled in the same cycle, and that request is dropped.
- R9: The lookup hits an entry only when its valid bit is set and the address page lies between its first and last page, inclusive. Among several hits the lowest index is reported. On a hit the port gives the index, the Y flag and the pitch code. On a miss all of these read 0.
- R10: After reset the bank and the shadow copy are all zero, `busy` and `rej` are low, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Update request strobe |
| req_idx | input | 5 | Entry index to update |
| req_mode | input | 2 | 0 untiled/release, 1 X, 2 Y, 3 refused |
| req_start_pg | input | 20 | First 4 KiB page of the range |
| req_npages | input | 20 | Number of pages in the range |
| req_stride | input | 17 | Row stride in bytes |
| restore_req | input | 1 | Replay all shadow entries into the bank |
| busy | output | 1 | Commit sequence in progress |
| rej | output | 1 | One-cycle pulse for a refused request |
| bus_we | output | 1 | Register bus write strobe |
| bus_re | output | 1 | Register bus readback strobe |
| bus_addr | output | 6 | Register bus word address |
| bus_wdata | output | 32 | Register bus write data |
| bus_rdata | output | 32 | Bank read data at `bus_addr` |
| lk_addr | input | 32 | Lookup byte address |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_idx | output | 5 | Index of the lowest matching entry |
| lk_ytile | output | 1 | Y tiling flag of the matching entry |
| lk_pitch | output | 10 | Pitch code of the matching entry |

## Verification
The commit path is driven with X and Y entries whose ranges overlap. It is also driven with a range that ends exactly at the top page and with a minimum-pitch entry. Together these show whether the pitch, Y flag and end-page arithmetic are encoded correctly, and whether the lookup priority is taken by the lowest index. Each refusal cause is sent on its own to an entry that already holds a live fence. A wrongly accepted request would therefore be visible as a changed lookup result. A second request is sent while an update is running, and a restore is sent in the same cycle as a request. These two cases tell apart correct ignore and priority behaviour from a sequencer that restarts or merges the requests.

// File: rtl/fence_pkg.sv
package fence_pkg;
  localparam int PG_W        = 20;
  localparam int STRIDE_W    = 17;
  localparam int PITCH_W     = 10;
  localparam int PAGE_SHIFT  = 12;
  localparam int UNIT_SHIFT  = 7;
  localparam int PITCH_LSB   = 2;
  localparam int YFLAG_BIT   = 1;
  localparam int VALID_BIT   = 0;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_X    = 2'd1,
    MODE_Y    = 2'd2,
    MODE_BAD  = 2'd3
  } tile_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_RB_CLR,
    ST_HI,
    ST_LO,
    ST_RB_LO
  } seq_st_e;
endpackage

// File: rtl/fence_encode.sv
module fence_encode
  import fence_pkg::*;
(
  input  logic [1:0]          mode,
  input  logic [PG_W-1:0]     start_pg,
  input  logic [PG_W-1:0]     npages,
  input  logic [STRIDE_W-1:0] stride,
  output logic [31:0]         word_hi,
  output logic [31:0]         word_lo,
  output logic                bad
);
  logic [PG_W:0]    end_sum;
  logic [PITCH_W-1:0] pitch;
  logic             tiled;
  logic             stride_bad;

  always_comb begin
    end_sum    = {1'b0, start_pg} + {1'b0, npages} - {{PG_W{1'b0}}, 1'b1};
    tiled      = (mode == MODE_X) || (mode == MODE_Y);
    stride_bad = (stride[UNIT_SHIFT-1:0] != '0) ||
                 (stride[STRIDE_W-1:UNIT_SHIFT] == '0);
    pitch      = stride[STRIDE_W-1:UNIT_SHIFT] - {{(PITCH_W-1){1'b0}}, 1'b1};
    bad        = (mode == MODE_BAD) ||
                 (tiled && (stride_bad || (npages == '0) || end_sum[PG_W]));
    word_hi    = '0;
    word_lo    = '0;
    if (tiled) begin
      word_hi = {end_sum[PG_W-1:0], {PAGE_SHIFT{1'b0}}};
      word_lo = {start_pg, pitch, (mode == MODE_Y), 1'b1};
    end
  end
endmodule

// File: rtl/fence_bank.sv
module fence_bank
  import fence_pkg::*;
#(
  parameter int NUM_FENCES = 32,
  parameter int IDX_W      = $clog2(NUM_FENCES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W:0]     addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [31:0]        lk_addr,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic               lk_ytile,
  output logic [PITCH_W-1:0] lk_pitch
);
  logic [31:0] lo_q [NUM_FENCES];
  logic [31:0] hi_q [NUM_FENCES];
  logic [NUM_FENCES-1:0] match;
  logic [PG_W-1:0] lk_pg;
  logic [PAGE_SHIFT-1:0] lk_unused;

  assign lk_pg     = lk_addr[31:PAGE_SHIFT];
  assign lk_unused = lk_addr[PAGE_SHIFT-1:0];

  for (genvar i = 0; i < NUM_FENCES; i++) begin : g_ent
    logic wr_lo, wr_hi;
    assign wr_lo = we && (addr == {IDX_W'(i), 1'b0});
    assign wr_hi = we && (addr == {IDX_W'(i), 1'b1});

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[i] <= '0;
      end else if (wr_lo) begin
        lo_q[i] <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[i] <= '0;
      end else if (wr_hi) begin
        hi_q[i] <= wdata;
      end
    end

    assign match[i] = lo_q[i][VALID_BIT] &&
                      (lk_pg >= lo_q[i][31:PAGE_SHIFT]) &&
                      (lk_pg <= hi_q[i][31:PAGE_SHIFT]);
  end

  assign rdata = addr[0] ? hi_q[addr[IDX_W:1]] : lo_q[addr[IDX_W:1]];

  always_comb begin
    lk_hit   = 1'b0;
    lk_idx   = '0;
    lk_ytile = 1'b0;
    lk_pitch = '0;
    for (int i = NUM_FENCES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit   = 1'b1;
        lk_idx   = IDX_W'(i);
        lk_ytile = lo_q[i][YFLAG_BIT];
        lk_pitch = lo_q[i][PITCH_LSB +: PITCH_W];
      end
    end
  end

  // R5: a high word only lands while its entry is switched off
  a_r5_hi_while_off: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[0]) |-> !lo_q[addr[IDX_W:1]][VALID_BIT]);

  // R9: a reported hit carries the valid entry's own flag and pitch
  a_r9_hit_fields: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pitch == lo_q[lk_idx][PITCH_LSB +: PITCH_W]));
endmodule

// File: rtl/fence_seq.sv
module fence_seq
  import fence_pkg::*;
#(
  parameter int NUM_FENCES = 32,
  parameter int IDX_W      = $clog2(NUM_FENCES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restore_req,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             enc_bad,
  input  logic [31:0]      enc_hi,
  input  logic [31:0]      enc_lo,
  input  logic [31:0]      rdata,
  output logic             busy,
  output logic             rej,
  output logic             bus_we,
  output logic             bus_re,
  output logic [IDX_W:0]   bus_addr,
  output logic [31:0]      bus_wdata
);
  seq_st_e          state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rest_q, rest_d;
  logic             rej_q, rej_d;
  logic             sh_we;
  logic             bus_hi;
  logic [31:0]      sh_lo [NUM_FENCES];
  logic [31:0]      sh_hi [NUM_FENCES];

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    rest_d  = rest_q;
    rej_d   = 1'b0;
    sh_we   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (restore_req) begin
          state_d = ST_CLR;
          idx_d   = '0;
          rest_d  = 1'b1;
        end else if (req_valid) begin
          if (enc_bad) begin
            rej_d = 1'b1;
          end else begin
            sh_we   = 1'b1;
            idx_d   = req_idx;
            rest_d  = 1'b0;
            state_d = ST_CLR;
          end
        end
      end
      ST_CLR:    state_d = ST_RB_CLR;
      ST_RB_CLR: state_d = ST_HI;
      ST_HI:     state_d = ST_LO;
      ST_LO:     state_d = ST_RB_LO;
      ST_RB_LO: begin
        if (rest_q && (idx_q != IDX_W'(NUM_FENCES - 1))) begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_CLR;
        end else begin
          rest_d  = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rest_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rest_q  <= rest_d;
      rej_q   <= rej_d;
    end
  end

  for (genvar i = 0; i < NUM_FENCES; i++) begin : g_sh
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_lo[i] <= '0;
        sh_hi[i] <= '0;
      end else if (sh_we && (req_idx == IDX_W'(i))) begin
        sh_lo[i] <= enc_lo;
        sh_hi[i] <= enc_hi;
      end
    end
  end

  always_comb begin
    bus_we    = 1'b0;
    bus_re    = 1'b0;
    bus_hi    = 1'b0;
    bus_wdata = '0;
    case (state_q)
      ST_CLR:    bus_we = 1'b1;
      ST_RB_CLR: bus_re = 1'b1;
      ST_HI: begin
        bus_we    = 1'b1;
        bus_hi    = 1'b1;
        bus_wdata = sh_hi[idx_q];
      end
      ST_LO: begin
        bus_we    = 1'b1;
        bus_wdata = sh_lo[idx_q];
      end
      ST_RB_LO:  bus_re = 1'b1;
      default:   ;
    endcase
  end

  assign bus_addr = {idx_q, bus_hi};
  assign busy     = (state_q != ST_IDLE);
  assign rej      = rej_q;

  // R6: the clearing write has reached the bank before the high word goes out
  a_r6_clear_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RB_CLR) |-> (rdata == 32'd0));

  // R6: the final readback returns the committed low word
  a_r6_commit_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RB_LO) |-> (rdata == sh_lo[idx_q]));

  // R3: a refusal never starts a sequence
  a_r3_rej_no_seq: assert property (@(posedge clk) disable iff (!rst_n)
    rej |-> !busy);

  // R5: at most one bus operation per cycle
  a_r5_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_we, bus_re}));

  // R7: the entry being committed does not change mid-sequence
  a_r7_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HI) |=> ((state_q == ST_LO) && $stable(idx_q)));
endmodule

// File: rtl/fence_seq_top.sv
module fence_seq_top
  import fence_pkg::*;
#(
  parameter int NUM_FENCES = 32,
  parameter int IDX_W      = $clog2(NUM_FENCES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [IDX_W-1:0]   req_idx,
  input  logic [1:0]         req_mode,
  input  logic [PG_W-1:0]    req_start_pg,
  input  logic [PG_W-1:0]    req_npages,
  input  logic [STRIDE_W-1:0] req_stride,
  input  logic               restore_req,
  output logic               busy,
  output logic               rej,
  output logic               bus_we,
  output logic               bus_re,
  output logic [IDX_W:0]     bus_addr,
  output logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [31:0]        lk_addr,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic               lk_ytile,
  output logic [PITCH_W-1:0] lk_pitch
);
  logic [1:0]  rst_sync_q;
  logic        rst_n_i;
  logic [31:0] enc_hi, enc_lo;
  logic        enc_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync_q[1];

  fence_encode u_enc (
    .mode     (req_mode),
    .start_pg (req_start_pg),
    .npages   (req_npages),
    .stride   (req_stride),
    .word_hi  (enc_hi),
    .word_lo  (enc_lo),
    .bad      (enc_bad)
  );

  fence_seq #(.NUM_FENCES(NUM_FENCES), .IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .restore_req (restore_req),
    .req_valid   (req_valid),
    .req_idx     (req_idx),
    .enc_bad     (enc_bad),
    .enc_hi      (enc_hi),
    .enc_lo      (enc_lo),
    .rdata       (bus_rdata),
    .busy        (busy),
    .rej         (rej),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata)
  );

  fence_bank #(.NUM_FENCES(NUM_FENCES), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .lk_addr  (lk_addr),
    .lk_hit   (lk_hit),
    .lk_idx   (lk_idx),
    .lk_ytile (lk_ytile),
    .lk_pitch (lk_pitch)
  );
endmodule

// File: tb/fence_seq_top_tb_top.sv
`timescale 1ns/1ps
module fence_seq_top_tb_top;
  localparam int N = 32;

  logic        clk, rst_n;
  logic        req_valid, restore_req;
  logic [4:0]  req_idx;
  logic [1:0]  req_mode;
  logic [19:0] req_start_pg, req_npages;
  logic [16:0] req_stride;
  logic        busy, rej, bus_we, bus_re;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, lk_addr;
  logic        lk_hit, lk_ytile;
  logic [4:0]  lk_idx;
  logic [9:0]  lk_pitch;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  fence_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .req_mode(req_mode), .req_start_pg(req_start_pg), .req_npages(req_npages),
    .req_stride(req_stride), .restore_req(restore_req), .busy(busy), .rej(rej),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_ytile(lk_ytile), .lk_pitch(lk_pitch)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];
  logic [31:0] s_lo [N];
  logic [31:0] s_hi [N];
  int m_step, m_idx;
  bit m_rest, m_rej;

  task automatic encode(input logic [1:0] mode, input longint st, input longint np,
                        input longint sd, output bit bad,
                        output logic [31:0] hi, output logic [31:0] lo);
    bit tiled;
    tiled = (mode == 2'd1) || (mode == 2'd2);
    bad = (mode == 2'd3);
    hi = '0;
    lo = '0;
    if (tiled) begin
      if (sd == 0 || (sd % 128) != 0 || np == 0 || (st + np - 1) > 64'hFFFFF) bad = 1;
      hi = 32'((st + np - 1) * 4096);
      lo = 32'(st * 4096 + ((sd / 128) - 1) * 4 + ((mode == 2'd2) ? 2 : 0) + 1);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_idx = 0; m_rest = 0; m_rej = 0;
      for (int i = 0; i < N; i++) begin
        m_lo[i] = '0; m_hi[i] = '0; s_lo[i] = '0; s_hi[i] = '0;
      end
    end else begin
      m_rej = 0;
      case (m_step)
        0: begin
          if (restore_req) begin
            m_rest = 1; m_idx = 0; m_step = 1;
          end else if (req_valid) begin
            bit b;
            logic [31:0] h, l;
            encode(req_mode, req_start_pg, req_npages, req_stride, b, h, l);
            if (b) m_rej = 1;
            else begin
              s_hi[req_idx] = h; s_lo[req_idx] = l;
              m_idx = req_idx; m_rest = 0; m_step = 1;
            end
          end
        end
        1: begin m_lo[m_idx] = '0; m_step = 2; end
        2: m_step = 3;
        3: begin m_hi[m_idx] = s_hi[m_idx]; m_step = 4; end
        4: begin m_lo[m_idx] = s_lo[m_idx]; m_step = 5; end
        default: begin
          if (m_rest && m_idx < N - 1) begin m_idx++; m_step = 1; end
          else begin m_step = 0; m_rest = 0; end
        end
      endcase
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_we, e_re, e_hit, e_y;
      logic [5:0]  e_addr;
      logic [31:0] e_wd;
      logic [4:0]  e_idx;
      logic [9:0]  e_pitch;
      e_we = (m_step == 1) || (m_step == 3) || (m_step == 4);
      e_re = (m_step == 2) || (m_step == 5);
      e_addr = 6'(m_idx * 2 + ((m_step == 3) ? 1 : 0));
      e_wd = (m_step == 3) ? s_hi[m_idx] : (m_step == 4) ? s_lo[m_idx] : 32'd0;
      chk("R7 busy", 64'(busy), 64'(m_step != 0));
      chk("R3 rej", 64'(rej), 64'(m_rej));
      chk("R5 bus_we", 64'(bus_we), 64'(e_we));
      chk("R5 bus_re", 64'(bus_re), 64'(e_re));
      if (e_we || e_re) chk("R5 bus_addr", 64'(bus_addr), 64'(e_addr));
      if (m_step == 3) chk("R1 high word", 64'(bus_wdata), 64'(e_wd));
      if (m_step == 1 || m_step == 4) chk("R2 low word", 64'(bus_wdata), 64'(e_wd));
      if (m_step == 2) chk("R6 first readback", 64'(bus_rdata), 64'd0);
      if (m_step == 5) chk("R6 final readback", 64'(bus_rdata), 64'(s_lo[m_idx]));
      e_hit = 0; e_idx = '0; e_y = 0; e_pitch = '0;
      for (int i = N - 1; i >= 0; i--) begin
        if (m_lo[i][0] && lk_addr[31:12] >= m_lo[i][31:12] && lk_addr[31:12] <= m_hi[i][31:12]) begin
          e_hit = 1; e_idx = 5'(i); e_y = m_lo[i][1]; e_pitch = m_lo[i][11:2];
        end
      end
      chk("R9 lookup", {42'd0, lk_hit, lk_idx, lk_ytile, lk_pitch, 5'd0},
                       {42'd0, e_hit, e_idx, e_y, e_pitch, 5'd0});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic issue(input int idx, input logic [1:0] mode, input int st, input int np,
                       input int sd, input bit exp_rej, input string tag);
    @(negedge clk); #1;
    req_valid = 1; req_idx = 5'(idx); req_mode = mode;
    req_start_pg = 20'(st); req_npages = 20'(np); req_stride = 17'(sd);
    @(negedge clk);
    chk(tag, 64'(rej), 64'(exp_rej));
    #1 req_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic look(input logic [31:0] a, input bit hit, input int idx, input string tag);
    @(negedge clk); #1 lk_addr = a;
    @(negedge clk);
    chk(tag, {lk_hit, 5'(lk_idx)}, {hit, 5'(hit ? idx : 0)});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    rst_n = 0; req_valid = 0; restore_req = 0; req_idx = '0; req_mode = '0;
    req_start_pg = '0; req_npages = '0; req_stride = '0; lk_addr = '0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10 busy after reset", 64'(busy), 64'd0);
    chk("R10 rej after reset", 64'(rej), 64'd0);
    look(32'h0, 0, 0, "R10 lookup at zero");
    look(32'h0010_5000, 0, 0, "R10 lookup mid space");

    // R1 R2: X and overlapping Y entries
    issue(3, 2'd1, 'h100, 16, 512, 0, "R2 X accept");
    wait_idle();
    issue(1, 2'd2, 'h105, 4, 65536, 0, "R2 Y accept");
    wait_idle();
    look(32'h0010_5000, 1, 1, "R9 overlap lowest index");
    look(32'h0010_4FFF, 1, 3, "R9 below Y range");
    look(32'h0010_8FFC, 1, 1, "R9 last page inclusive");
    look(32'h0010_9000, 1, 3, "R9 past Y end");
    look(32'h0010_FFFF, 1, 3, "R9 X end page");
    look(32'h0011_0000, 0, 0, "R9 past X end");
    look(32'h000F_FFFF, 0, 0, "R9 before X start");

    // R1: range ending at the top page, minimum pitch
    issue(31, 2'd1, 'hFFFFF, 1, 128, 0, "R1 top page accept");
    wait_idle();
    look(32'hFFFF_FFFF, 1, 31, "R1 top page lookup");

    // R7: second request while busy is ignored
    issue(5, 2'd2, 'h300, 2, 256, 0, "R7 first accept");
    issue(6, 2'd1, 'h200, 2, 256, 0, "R7 busy request no rej");
    wait_idle();
    look(32'h0020_0000, 0, 0, "R7 ignored request left no entry");
    look(32'h0030_1000, 1, 5, "R7 first request live");

    // R3: each refusal cause, aimed at live entry 3
    issue(3, 2'd1, 'h400, 4, 200, 1, "R3 stride not multiple");
    issue(3, 2'd2, 'h400, 4, 0, 1, "R3 stride zero");
    issue(3, 2'd1, 'h400, 0, 512, 1, "R3 zero pages");
    issue(3, 2'd1, 'hFFFFF, 2, 512, 1, "R3 end overflow");
    issue(3, 2'd3, 'h400, 4, 512, 1, "R3 mode three");
    look(32'h0010_F000, 1, 3, "R3 entry 3 untouched");
    look(32'h0040_0000, 0, 0, "R3 no new range");

    // R4: release entry 1
    issue(1, 2'd0, 'h105, 4, 65536, 0, "R4 release accept");
    wait_idle();
    look(32'h0010_5000, 1, 3, "R4 released entry gone");

    // R8: restore together with a request, restore wins
    @(negedge clk); #1;
    restore_req = 1; req_valid = 1; req_idx = 5'd7; req_mode = 2'd1;
    req_start_pg = 20'h500; req_npages = 20'd1; req_stride = 17'd128;
    @(negedge clk); #1;
    restore_req = 0; req_valid = 0;
    cyc = 1;
    @(negedge clk);
    while (busy) begin cyc++; @(negedge clk); end
    chk("R8 restore length", 64'(cyc), 64'd160);
    look(32'h0050_0000, 0, 0, "R8 request dropped on restore");
    look(32'h0010_5000, 1, 3, "R8 bank matches shadow");
    look(32'hFFFF_F000, 1, 31, "R8 top entry replayed");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule